// File: doc/BRIEF.md
# Two-Chunk Receive Bus to Packet Stream Adapter

This block sits behind a wide receive bus that can carry up to two packet chunks in one clock cycle. Each chunk has its own word count, channel number, start marker, end-of-burst marker, error flag and end-of-packet code. The adapter splits every input cycle into separate chunks and presents them one per beat on a streaming output. The output carries data, byte keeps, a last flag, an error flag in tuser and a channel sideband.

The input bus is N 64-bit words wide, with the most significant word first, and is divided into S equal segments. The first chunk fills the top words. The second chunk starts at the first segment boundary at or after the end of the first chunk. The input has no backpressure, so a small queue absorbs the cycles that carry two chunks. If the queue is full, the incoming chunk is dropped and a sticky overflow flag is raised. The output has no ready signal and drains one entry per cycle whenever the queue holds anything.

Top module: `twoChunkStreamAdapter`

## Requirements
- R1: A first chunk with count c (1..N) is emitted with the top c input words, left-aligned in outData. Words at index c and below carry zero data and zero keep. Word 0 sits at outData[N*64-1 -: 64].
- R2: A second chunk with count d starts at input word b, where b is cntA rounded up to a multiple of N/S. Its d words are emitted left-aligned, with the unused words zeroed. When S is 1, cntB is ignored.
- R3: Every emitted word below the chunk's count has all 8 keep bits set. The exception is an end code 4'b1kkk with kkk not 0: the chunk's final word then keeps only its top kkk byte lanes. Keep bit j covers byte bits [8j+7:8j].
- R4: outLast is 1 exactly when the chunk's end code has bit 3 set or equals 4'b0001.
- R5: outUser is 1 when the chunk's end code is 4'b0001, or when its end-of-burst input and its error input are both high. An error input with end-of-burst low has no effect.
- R6: A chunk whose start input is high and whose count is non-zero takes its own channel input. Otherwise a first chunk takes the held channel, and a second chunk takes the channel of the first chunk in the same cycle. The held channel is the channel of the last non-empty chunk, and is 0 after reset.
- R7: A chunk with count 0 produces no beat. A cycle with both counts 0 produces no beat.
- R8: Chunks leave in arrival order, with the first chunk of a cycle before the second, at one beat per cycle. A chunk accepted at a clock edge is visible from that edge when the queue was empty.
- R9: The queue holds DEPTH entries (at least 4). A chunk that finds no free entry, counting the entry popped at the same edge, is dropped and sets overflow. Overflow stays set until reset.
- R10: After reset, outValid and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWords | input | N*64 | Input data words, word 0 in the top bits |
| inCntA | input | $clog2(N+1) | Word count of the first chunk |
| inCntB | input | $clog2(N+1) | Word count of the second chunk |
| inChanA | input | 8 | Channel of the first chunk |
| inChanB | input | 8 | Channel of the second chunk |
| inStartA | input | 1 | Burst/packet start for the first chunk |
| inStartB | input | 1 | Burst/packet start for the second chunk |
| inEndA | input | 1 | End of burst for the first chunk |
| inEndB | input | 1 | End of burst for the second chunk |
| inErrA | input | 1 | Error flag of the first chunk |
| inErrB | input | 1 | Error flag of the second chunk |
| inEopA | input | 4 | End-of-packet code of the first chunk |
| inEopB | input | 4 | End-of-packet code of the second chunk |
| outValid | output | 1 | Beat present |
| outData | output | N*64 | Beat data, left-aligned |
| outKeep | output | N*8 | Byte keeps |
| outLast | output | 1 | End of packet |
| outUser | output | 1 | Errored packet |
| outChan | output | 8 | Channel of the beat |
| overflow | output | 1 | Sticky queue overflow |

## Verification
Input is driven on a falling edge and captured at the next rising edge. With an empty queue, the resulting beat appears right after that edge, so the bench checks it at the following falling edge. A queued beat appears one cycle later for each entry ahead of it. The overflow flag rises after the same edge that drops a chunk. A bench model of the queue is stepped once per rising edge in the same order as the hardware: pop first, then push the first chunk, then the second. Every falling edge compares the ports against the model's head entry, so each result is checked in the exact cycle it is due.

// File: rtl/chunkAdaptPkg.sv
package chunkAdaptPkg;
  localparam int CHAN_W = 8;

  // Queue strobes from control to datapath
  typedef struct packed {
    logic pushA;
    logic pushB;
    logic pop;
  } qStrobe_t;

  // Per-chunk sideband stored beside the data
  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              last;
    logic              user;
  } chunkSide_t;

  function automatic logic endsPacket(input logic [3:0] code);
    return code[3] | (code == 4'b0001);
  endfunction

  function automatic logic isErrEnd(input logic [3:0] code);
    return code == 4'b0001;
  endfunction
endpackage

// File: rtl/chunkCtrl.sv
module chunkCtrl
  import chunkAdaptPkg::*;
#(
  parameter int N     = 8,
  parameter int S     = 2,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [$clog2(N+1)-1:0]    cntA,
  input  logic [$clog2(N+1)-1:0]    cntB,
  input  logic [CHAN_W-1:0]         chanA,
  input  logic [CHAN_W-1:0]         chanB,
  input  logic                      startA,
  input  logic                      startB,
  input  logic                      endA,
  input  logic                      endB,
  input  logic                      errA,
  input  logic                      errB,
  input  logic [3:0]                eopA,
  input  logic [3:0]                eopB,
  output qStrobe_t                  strobe,
  output chunkSide_t                sideA,
  output chunkSide_t                sideB,
  output logic                      outValid,
  output logic                      overflow
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic              validA, validB;
  logic [CNTW-1:0]   count;
  logic [CNTW:0]     free;
  logic [CHAN_W-1:0] heldChan, useChanA, useChanB;
  logic              pushA, pushB, pop, drop;

  assign validA = |cntA;

  generate
    if (S > 1) begin : gSecond
      assign validB = |cntB;
    end else begin : gSingle
      assign validB = 1'b0;
    end
  endgenerate

  // Channel selection: own on start, else inherited
  assign useChanA = (startA && validA) ? chanA : heldChan;
  assign useChanB = (startB && validB) ? chanB : useChanA;

  always_ff @(posedge clk) begin
    if (!rstN) heldChan <= '0;
    else if (validB) heldChan <= useChanB;
    else if (validA) heldChan <= useChanA;
  end

  always_comb begin
    sideA.chan = useChanA;
    sideA.last = endsPacket(eopA);
    sideA.user = isErrEnd(eopA) | (endA & errA);
    sideB.chan = useChanB;
    sideB.last = endsPacket(eopB);
    sideB.user = isErrEnd(eopB) | (endB & errB);
  end

  // Queue occupancy and admission
  assign pop  = (count != '0);
  assign free = (CNTW+1)'(DEPTH) - {1'b0, count} + {{CNTW{1'b0}}, pop};
  assign pushA = validA && (free >= (CNTW+1)'(1));
  assign pushB = validB && (free >= (pushA ? (CNTW+1)'(2) : (CNTW+1)'(1)));
  assign drop  = (validA && !pushA) || (validB && !pushB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      count <= count + CNTW'(pushA) + CNTW'(pushB) - CNTW'(pop);
      if (drop) overflow <= 1'b1;
    end
  end

  assign strobe.pushA = pushA;
  assign strobe.pushB = pushB;
  assign strobe.pop   = pop;
  assign outValid     = pop;

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R7
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !validA && !validB) |=> !outValid);
  // R8
  one_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNTW'(1) && !pushA && !pushB) |=> !outValid);
endmodule

// File: rtl/chunkPath.sv
module chunkPath
  import chunkAdaptPkg::*;
#(
  parameter int N     = 8,
  parameter int S     = 2,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [N*64-1:0]           words,
  input  logic [$clog2(N+1)-1:0]    cntA,
  input  logic [$clog2(N+1)-1:0]    cntB,
  input  logic [3:0]                eopA,
  input  logic [3:0]                eopB,
  input  qStrobe_t                  strobe,
  input  chunkSide_t                sideA,
  input  chunkSide_t                sideB,
  output logic [N*64-1:0]           outData,
  output logic [N*8-1:0]            outKeep,
  output logic                      outLast,
  output logic                      outUser,
  output logic [CHAN_W-1:0]         outChan
);
  localparam int CW  = $clog2(N + 1);
  localparam int SEG = N / S;
  localparam int PW  = $clog2(DEPTH);

  function automatic logic [N*8-1:0] keepFor(input logic [CW-1:0] cnt,
                                             input logic [3:0] code);
    logic [N*8-1:0] k;
    k = '0;
    for (int w = 0; w < N; w++) begin
      if (CW'(w) < cnt) begin
        k[(N-1-w)*8 +: 8] = 8'hFF;
        if (CW'(w + 1) == cnt && code[3] && code[2:0] != 3'd0)
          k[(N-1-w)*8 +: 8] = ~(8'hFF >> code[2:0]);
      end
    end
    return k;
  endfunction

  function automatic logic [N*64-1:0] maskWords(input logic [N*64-1:0] d,
                                                input logic [CW-1:0] cnt);
    logic [N*64-1:0] m;
    m = '0;
    for (int w = 0; w < N; w++)
      if (CW'(w) < cnt) m[(N-1-w)*64 +: 64] = d[(N-1-w)*64 +: 64];
    return m;
  endfunction

  // Second chunk start: first segment boundary at or after cntA
  logic [CW-1:0]   bStart;
  logic [N*64-1:0] shiftedB, dataA, dataB;
  logic [N*8-1:0]  keepA, keepB;

  always_comb begin
    bStart = CW'(N);
    for (int k = S - 1; k >= 0; k--)
      if (CW'(k * SEG) >= cntA) bStart = CW'(k * SEG);
  end

  assign shiftedB = words << {bStart, 6'b0};
  assign dataA    = maskWords(words, cntA);
  assign dataB    = maskWords(shiftedB, cntB);
  assign keepA    = keepFor(cntA, eopA);
  assign keepB    = keepFor(cntB, eopB);

  // Entry storage
  logic [N*64-1:0] memData [DEPTH];
  logic [N*8-1:0]  memKeep [DEPTH];
  chunkSide_t      memSide [DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr, wrPtrB;

  assign wrPtrB = wrPtr + PW'(strobe.pushA);

  always_ff @(posedge clk) begin
    if (strobe.pushA) begin
      memData[wrPtr] <= dataA;
      memKeep[wrPtr] <= keepA;
      memSide[wrPtr] <= sideA;
    end
    if (strobe.pushB) begin
      memData[wrPtrB] <= dataB;
      memKeep[wrPtrB] <= keepB;
      memSide[wrPtrB] <= sideB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(strobe.pushA) + PW'(strobe.pushB);
      rdPtr <= rdPtr + PW'(strobe.pop);
    end
  end

  assign outData = memData[rdPtr];
  assign outKeep = memKeep[rdPtr];
  assign outLast = memSide[rdPtr].last;
  assign outUser = memSide[rdPtr].user;
  assign outChan = memSide[rdPtr].chan;

  // R1
  head_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> outKeep[N*8-1]);
  // R3
  partial_only_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !outLast) |-> (outKeep[N*8-1 -: 8] == 8'hFF));
endmodule

// File: rtl/twoChunkStreamAdapter.sv
module twoChunkStreamAdapter
  import chunkAdaptPkg::*;
#(
  parameter int N     = 8,
  parameter int S     = 2,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [N*64-1:0]           inWords,
  input  logic [$clog2(N+1)-1:0]    inCntA,
  input  logic [$clog2(N+1)-1:0]    inCntB,
  input  logic [7:0]                inChanA,
  input  logic [7:0]                inChanB,
  input  logic                      inStartA,
  input  logic                      inStartB,
  input  logic                      inEndA,
  input  logic                      inEndB,
  input  logic                      inErrA,
  input  logic                      inErrB,
  input  logic [3:0]                inEopA,
  input  logic [3:0]                inEopB,
  output logic                      outValid,
  output logic [N*64-1:0]           outData,
  output logic [N*8-1:0]            outKeep,
  output logic                      outLast,
  output logic                      outUser,
  output logic [7:0]                outChan,
  output logic                      overflow
);
  qStrobe_t   strobe;
  chunkSide_t sideA, sideB;

  chunkCtrl #(.N(N), .S(S), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cntA(inCntA), .cntB(inCntB),
    .chanA(inChanA), .chanB(inChanB),
    .startA(inStartA), .startB(inStartB),
    .endA(inEndA), .endB(inEndB),
    .errA(inErrA), .errB(inErrB),
    .eopA(inEopA), .eopB(inEopB),
    .strobe(strobe), .sideA(sideA), .sideB(sideB),
    .outValid(outValid), .overflow(overflow)
  );

  chunkPath #(.N(N), .S(S), .DEPTH(DEPTH)) path_i (
    .clk(clk), .rstN(rstN),
    .words(inWords), .cntA(inCntA), .cntB(inCntB),
    .eopA(inEopA), .eopB(inEopB),
    .strobe(strobe), .sideA(sideA), .sideB(sideB),
    .outData(outData), .outKeep(outKeep),
    .outLast(outLast), .outUser(outUser), .outChan(outChan)
  );
endmodule

// File: tb/twoChunkStreamAdapter_tb_top.sv
module twoChunkStreamAdapter_tb_top;
  localparam int N = 8;
  localparam int S = 2;
  localparam int D = 4;
  localparam int SEG = N / S;

  typedef struct {
    logic [N*64-1:0] data;
    logic [N*8-1:0]  keep;
    logic            last;
    logic            user;
    logic [7:0]      chan;
  } beat_t;

  logic clk = 1'b0;
  logic rstN;
  logic [N*64-1:0] inWords;
  logic [3:0] inCntA, inCntB, inEopA, inEopB;
  logic [7:0] inChanA, inChanB;
  logic inStartA, inStartB, inEndA, inEndB, inErrA, inErrB;
  logic outValid, outLast, outUser, overflow;
  logic [N*64-1:0] outData;
  logic [N*8-1:0] outKeep;
  logic [7:0] outChan;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  beat_t mq[$];
  logic  mOvf;
  logic [7:0] mHeld;

  always #5 clk = ~clk;

  twoChunkStreamAdapter #(.N(N), .S(S), .DEPTH(D)) dut_i (
    .clk(clk), .rstN(rstN), .inWords(inWords),
    .inCntA(inCntA), .inCntB(inCntB), .inChanA(inChanA), .inChanB(inChanB),
    .inStartA(inStartA), .inStartB(inStartB), .inEndA(inEndA), .inEndB(inEndB),
    .inErrA(inErrA), .inErrB(inErrB), .inEopA(inEopA), .inEopB(inEopB),
    .outValid(outValid), .outData(outData), .outKeep(outKeep),
    .outLast(outLast), .outUser(outUser), .outChan(outChan), .overflow(overflow)
  );

  function automatic logic [63:0] inWord(input int w);
    return (w < N) ? inWords[(N-1-w)*64 +: 64] : 64'd0;
  endfunction

  function automatic logic [N*8-1:0] expKeep(input int cnt, input logic [3:0] code);
    logic [N*8-1:0] k = '0;
    for (int w = 0; w < cnt; w++) begin
      logic [7:0] b = 8'hFF;
      if (w == cnt - 1 && code[3] && code[2:0] != 0) begin
        b = 8'h00;
        for (int j = 0; j < int'(code[2:0]); j++) b[7-j] = 1'b1;
      end
      k[(N-1-w)*8 +: 8] = b;
    end
    return k;
  endfunction

  function automatic beat_t mkBeat(input int start, input int cnt, input logic [3:0] code,
                                   input logic endB, input logic err, input logic [7:0] ch);
    beat_t r;
    r.data = '0;
    for (int w = 0; w < cnt; w++) r.data[(N-1-w)*64 +: 64] = inWord(start + w);
    r.keep = expKeep(cnt, code);
    r.last = code[3] || code == 4'b0001;
    r.user = (code == 4'b0001) || (endB && err);
    r.chan = ch;
    return r;
  endfunction

  task automatic modelStep();
    int ca = int'(inCntA);
    int cb = int'(inCntB);
    logic [7:0] chA, chB;
    int freeSlots;
    if (mq.size() > 0) void'(mq.pop_front());
    freeSlots = D - mq.size();
    chA = (inStartA && ca != 0) ? inChanA : mHeld;
    chB = (inStartB && cb != 0) ? inChanB : chA;
    if (ca != 0) begin
      if (freeSlots > 0) begin
        mq.push_back(mkBeat(0, ca, inEopA, inEndA, inErrA, chA));
        freeSlots--;
      end else mOvf = 1'b1;
      mHeld = chA;
    end
    if (cb != 0) begin
      if (freeSlots > 0) mq.push_back(mkBeat(((ca + SEG - 1) / SEG) * SEG, cb, inEopB, inEndB, inErrB, chB));
      else mOvf = 1'b1;
      mHeld = chB;
    end
  endtask

  task automatic checkOut();
    logic expV = (mq.size() > 0);
    vectors++;
    if (outValid !== expV) begin
      miscompares++;
      $display("FAIL R7/R8 valid: got %b exp %b", outValid, expV);
    end else if (expV) begin
      if (outData !== mq[0].data) begin
        miscompares++; $display("FAIL R1/R2 data: got %h exp %h", outData, mq[0].data);
      end
      if (outKeep !== mq[0].keep) begin
        miscompares++; $display("FAIL R3 keep: got %h exp %h", outKeep, mq[0].keep);
      end
      if (outLast !== mq[0].last) begin
        miscompares++; $display("FAIL R4 last: got %b exp %b", outLast, mq[0].last);
      end
      if (outUser !== mq[0].user) begin
        miscompares++; $display("FAIL R5 user: got %b exp %b", outUser, mq[0].user);
      end
      if (outChan !== mq[0].chan) begin
        miscompares++; $display("FAIL R6 chan: got %h exp %h", outChan, mq[0].chan);
      end
    end
    if (overflow !== mOvf) begin
      miscompares++; $display("FAIL R9 overflow: got %b exp %b", overflow, mOvf);
    end
  endtask

  task automatic setIn(input int ca, input int cb, input logic [3:0] ea, input logic [3:0] eb,
                       input logic sa, input logic sb, input logic [7:0] cha, input logic [7:0] chb,
                       input logic ena, input logic enb, input logic era, input logic erb);
    for (int w = 0; w < N; w++) inWords[w*64 +: 64] = {$urandom, $urandom};
    inCntA = 4'(ca); inCntB = 4'(cb); inEopA = ea; inEopB = eb;
    inStartA = sa; inStartB = sb; inChanA = cha; inChanB = chb;
    inEndA = ena; inEndB = enb; inErrA = era; inErrB = erb;
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    checkOut();
  endtask

  task automatic idle();
    setIn(0, 0, 4'h0, 4'h0, 0, 0, 8'h0, 8'h0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mq.delete();
    mOvf = 1'b0;
    mHeld = 8'h00;
    // R10: reset state
    vectors++;
    if (outValid !== 1'b0 || overflow !== 1'b0) begin
      miscompares++;
      $display("FAIL R10 reset: got valid %b ovf %b exp 0 0", outValid, overflow);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // R3: explicit keep literal, 1 word with 3 valid bytes
    setIn(1, 0, 4'b1011, 4'h0, 1, 0, 8'h11, 8'h0, 1, 0, 0, 0);
    tick();
    vectors++;
    if (outKeep !== 64'hE000_0000_0000_0000) begin
      miscompares++; $display("FAIL R3 literal keep: got %h exp %h", outKeep, 64'hE000_0000_0000_0000);
    end
    // R2: A=3 words, B=4 words at word 4
    setIn(3, 4, 4'b1000, 4'b1101, 0, 1, 8'h22, 8'h33, 1, 1, 0, 1);
    tick();
    // R2: A empty, B at word 0; R6 B start low inherits held
    setIn(0, 2, 4'h0, 4'b0001, 0, 0, 8'h44, 8'h55, 0, 1, 0, 0);
    tick();
    // R5: error with end-of-burst low has no effect
    setIn(5, 0, 4'h0, 4'h0, 1, 0, 8'h66, 8'h0, 0, 0, 1, 0);
    tick();
    // R7: zero-count cycles
    idle(); tick(); tick(); tick();
    // R6: continuation keeps channel 0x66
    setIn(8, 0, 4'b1000, 4'h0, 0, 0, 8'h77, 8'h0, 1, 0, 1, 0);
    tick();
    // R1: A=4 full, B=4 with cntA on boundary
    setIn(4, 4, 4'h0, 4'b1111, 1, 1, 8'h88, 8'h99, 0, 1, 0, 0);
    tick();
    idle(); repeat (4) tick();

    doReset();
    for (int i = 0; i < 600; i++) begin
      int ca = $urandom % 9;
      int cb = (ca <= SEG && ($urandom % 4) == 0) ? int'($urandom % (SEG + 1)) : 0;
      int r1 = $urandom % 10;
      int r2 = $urandom % 10;
      logic [3:0] ea = (r1 == 0) ? 4'b0001 : (r1 < 4) ? 4'b0000 : {1'b1, 3'($urandom)};
      logic [3:0] eb = (r2 == 0) ? 4'b0001 : (r2 < 4) ? 4'b0000 : {1'b1, 3'($urandom)};
      setIn(ca, cb, ea, eb, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      tick();
    end
    idle(); repeat (6) tick();

    // R9: sustained two-chunk cycles overflow the queue
    doReset();
    for (int i = 0; i < 6; i++) begin
      setIn(4, 4, 4'b1000, 4'b1000, 1, 1, 8'(i), 8'(i + 16), 1, 1, 0, 0);
      tick();
    end
    idle(); repeat (6) tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule